// File: doc/BRIEF.md
# Integer ALU with Narrow Variants

This block is the integer execution unit of a virtual-machine core. Each cycle that `in_valid` is high it takes two 64-bit operands and a 4-bit operation code. It computes one of fifteen integer operations and registers the answer. The answer appears on `result` one clock later, with `out_valid` high. Multiplication, division and floating point are done by other units.

The arithmetic and bitwise operations come in two widths. The full-width forms work on all 64 bits and wrap modulo 2^64. The narrow forms look only at the low 32 bits of each operand, wrap within 32 bits and zero-extend the answer. All shifts and rotates are 64-bit and take their distance from the low six bits of `b` alone. One code is unused: it gives a zero result and leaves the unit ready for the next operation.

Top module: `vm_int_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `result` are cleared to 0 at each clock edge.
- R2: An operation accepted with `in_valid` high at a clock edge shows on `result` with `out_valid` high right after the next edge. `out_valid` is low after any edge where `in_valid` was low.
- R3: Code 0 gives a+b and code 1 gives a-b, both modulo 2^64. For example, 0x8000000000000000 + 0x8000000000000000 = 0.
- R4: Code 2 gives a AND b, code 3 gives a OR b and code 4 gives a XOR b, over all 64 bits.
- R5: Codes 5, 6, 7, 8 and 9 are add, subtract, AND, OR and XOR on `a[31:0]` and `b[31:0]`. They wrap within 32 bits and zero-extend, so `result[63:32]` is 0. For example, 0xFFFFFFFF + 1 = 0 and 1 - 0xFFFFFFFF = 2.
- R6: Every shift and rotate uses only `b[5:0]` as its distance; `b[63:6]` has no effect.
- R7: Code 10 is a logical left shift and code 11 is a logical right shift; both fill with zeros.
- R8: Code 12 is an arithmetic right shift that fills with bit 63 of `a`. For example, -9 shifted by 2 gives -3, and 0x8000000000000000 shifted by 63 gives all ones.
- R9: Code 13 rotates `a` left and code 14 rotates it right. For example, rotating 3 right by 52 gives 0x3000.
- R10: Code 15 gives a result of 0, and the next operation is computed normally.
- R11: While `in_valid` is low, `result` keeps its last value, whatever the operands and code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 4 | Operation code |
| a | input | 64 | First operand |
| b | input | 64 | Second operand, also the shift or rotate distance |
| out_valid | output | 1 | `result` holds a new answer |
| result | output | 64 | Registered answer |

## Verification
The bench drives narrow operands whose upper words are nonzero. A unit that leaked the upper words or sign-extended would return nonzero bits in `result[63:32]`. Shift distances come with high bits set in `b`, such as 0x...C1 and 0x40. A unit that used the full `b` would shift everything out instead of moving by 1 or 0. Arithmetic shifts of negative values and of INT64_MIN by 63 expose a zero fill. Rotates by 1 across bit 63 and by 52 expose a rotate done as a plain shift. The unused code, followed at once by an add, checks that no stale value is returned and that the unit does not hang. Idle cycles with changing operands catch a result register that loads without `in_valid`.

// File: rtl/vm_int_alu.sv
module vm_int_alu #(
  parameter int W  = 64,
  parameter int NW = 32,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [OW-1:0] op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          out_valid,
  output logic [W-1:0]  result
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] sh;
  logic [SW:0]   sh_inv;
  logic [NW-1:0] al, bl;
  logic [W-1:0]  nxt;

  assign sh     = b[SW-1:0];
  assign sh_inv = (SW+1)'(W) - {1'b0, sh};
  assign al     = a[NW-1:0];
  assign bl     = b[NW-1:0];

  always_comb begin
    case (op)
      OW'(0):  nxt = a + b;
      OW'(1):  nxt = a - b;
      OW'(2):  nxt = a & b;
      OW'(3):  nxt = a | b;
      OW'(4):  nxt = a ^ b;
      OW'(5):  nxt = W'(NW'(al + bl));
      OW'(6):  nxt = W'(NW'(al - bl));
      OW'(7):  nxt = W'(al & bl);
      OW'(8):  nxt = W'(al | bl);
      OW'(9):  nxt = W'(al ^ bl);
      OW'(10): nxt = a << sh;
      OW'(11): nxt = a >> sh;
      OW'(12): nxt = W'($signed(a) >>> sh);
      OW'(13): nxt = (a << sh) | (a >> sh_inv);
      OW'(14): nxt = (a >> sh) | (a << sh_inv);
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/vm_int_alu_chk.sv
module vm_int_alu_chk #(
  parameter int W  = 64,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [OW-1:0] op,
  input logic          out_valid,
  input logic [W-1:0]  result
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_narrow_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= OW'(5) && op <= OW'(9)) |=> result[W-1:W/2] == '0);

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OW'(15)) |=> result == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

bind vm_int_alu vm_int_alu_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .result(result)
);

// File: tb/test_vm_int_alu.sv
module test_vm_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  always #5 clk = ~clk;

  vm_int_alu i_vm_int_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [63:0] x, input logic [63:0] y,
                       input logic [63:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = c; a = x; b = y;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op = 4'(i * 5); a = {32'hDEAD0000, 32'(i)}; b = ~a;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected out_valid", 64'd1, 64'd0);
      else check(tag_q.pop_front(), result, exp_q.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    check("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    drive(4'd0, 64'h8000000000000000, 64'h8000000000000000, 64'h0, "R3 add64 wrap");
    drive(4'd0, 64'hFFFFFFFF, 64'h1, 64'h100000000, "R3 add64 carry");
    drive(4'd1, 64'h1, 64'hFFFFFFFF, 64'hFFFFFFFF00000002, "R3 sub64");
    drive(4'd2, {16{4'hC}}, {16{4'hA}}, {16{4'h8}}, "R4 and64");
    drive(4'd3, {16{4'h4}}, {16{4'hA}}, {16{4'hE}}, "R4 or64");
    drive(4'd4, {16{4'h8}}, {16{4'hA}}, {16{4'h2}}, "R4 xor64");
    drive(4'd5, 64'hFFFFFFFF, 64'h1, 64'h0, "R5 add32 wrap");
    drive(4'd5, 64'hFF00000000000001, 64'h0000000100000001, 64'h2, "R5 add32 upper ignored");
    drive(4'd6, 64'h1, 64'hFFFFFFFF, 64'h2, "R5 sub32");
    drive(4'd7, {16{4'hC}}, {16{4'hA}}, 64'h88888888, "R5 and32");
    drive(4'd8, {16{4'h4}}, {16{4'hA}}, 64'hEEEEEEEE, "R5 or32");
    drive(4'd9, {16{4'h8}}, {16{4'hA}}, 64'h22222222, "R5 xor32");
    drive(4'd10, 64'h3, 64'd52, 64'h30000000000000, "R7 shl");
    drive(4'd10, 64'h8000000000000000, 64'd1, 64'h0, "R7 shl out");
    drive(4'd11, 64'h8000000000000000, 64'd1, 64'h4000000000000000, "R7 shr");
    drive(4'd11, 64'h3, 64'd52, 64'h0, "R7 shr out");
    drive(4'd12, 64'hFFFFFFFFFFFFFFF7, 64'd2, 64'hFFFFFFFFFFFFFFFD, "R8 sar -9");
    drive(4'd12, 64'h8000000000000000, 64'd63, 64'hFFFFFFFFFFFFFFFF, "R8 sar min");
    drive(4'd12, 64'h7FFFFFFFFFFFFFFF, 64'd163768499474606398, 64'h1, "R6 sar high b bits");
    drive(4'd10, 64'h1, 64'hFFFFFFFFFFFFFFC1, 64'h2, "R6 shl high b bits");
    drive(4'd13, 64'h8000000000000000, 64'd1, 64'h1, "R9 rol");
    drive(4'd14, 64'h8000000000000000, 64'd1, 64'h4000000000000000, "R9 ror");
    drive(4'd14, 64'h3, 64'd52, 64'd12288, "R9 ror 52");
    drive(4'd13, 64'h3, 64'd52, 64'h30000000000000, "R9 rol 52");
    drive(4'd13, 64'h123456789ABCDEF0, 64'h40, 64'h123456789ABCDEF0, "R6 rol by 64 is 0");
    drive(4'd15, 64'h1234, 64'h5678, 64'h0, "R10 unused code");
    drive(4'd0, 64'h1, 64'h1, 64'h2, "R10 next op after unused");
    idle(1);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      check("R11 hold result", result, last_exp);
      check("R2 no valid when idle", {63'd0, out_valid}, 64'd0);
    end
    idle(2);
    check("R2 all results delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule